// File: doc/BRIEF.md
# Masked Bus-Attribute Breakpoint Trigger

This block watches every processor bus cycle and raises a one-cycle trigger pulse when the cycle hits a programmed breakpoint. A breakpoint has three parts: a 16-bit attribute word, an address, and an optional data value. The attribute word pairs each bus attribute bit (read/write, access size, transfer type, transfer modifier) with a mask bit. A set mask bit removes its partner from the comparison. In address mode a hit needs the address and the masked attributes to match. In data mode the bus data must also equal the programmed data value.

The same three registers also serve the debug port's memory-access path. Any debug-port memory command writes its own attributes and address into them, and a debug-port write command also writes its data. This destroys whatever breakpoint was set up before. The attribute register is write-only. Its contents are only visible through the trigger they produce.

Two plain inputs replace the outer trigger-sequencing logic. One enables the comparator. The other marks a bus cycle as a debug-port access, and such a cycle never triggers.

Top module: `bkpt_attr_trigger`

## Requirements
- R1: After reset `trigger` is low. The attribute register holds 0x0005, which means no mask bits set, R=0, SZ=00, TT=00 and TM=101.
- R2: `trigger` goes high in the cycle after a bus cycle in which all of the following hold: `busValid`, `bkptEnable`, not `dbgAccess`, `busAddr` equal to the address register, and the masked attributes matching. It stays high for one cycle only for each such bus cycle.
- R3: Attribute bit 15 masks bit 7 (R). When bit 15 is clear, R must equal `busRead`.
- R4: Bits 14:13 mask the size field in bits 6:5, one bit each. Size codes are 00 longword, 01 byte, 10 word, 11 reserved.
- R5: Bits 12:11 mask the transfer-type field in bits 4:3, one bit each.
- R6: Bits 10:8 mask the transfer-modifier field in bits 2:0, one bit each.
- R7: When `dataMode` is high, a hit also needs `busData` to equal the data register.
- R8: A bus cycle with `dbgAccess` high never produces a trigger.
- R9: A debug-port command (`cmdValid`) loads `cmdAttr` into attribute bits 7:0, laid out as {R, SZ[1:0], TT[1:0], TM[2:0]}, and loads `cmdAddr` into the address register. Mask bits 15:8 are kept.
- R10: A debug-port write command (`cmdValid` and `cmdWrite`) loads `cmdData` into the data register. A read command leaves the data register unchanged.
- R11: While `bkptEnable` is low, no trigger is produced.
- R12: A configuration write (`cfgWrEn`) uses `cfgSel` to pick the target: 0 is the attribute register (from `cfgWrData[15:0]`), 1 is the address register and 2 is the data register. Code 3 is ignored. In a cycle where a debug-port command touches the same register, the command takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration target select |
| cfgWrData | input | 32 | Configuration write value |
| cmdValid | input | 1 | Debug-port memory command strobe |
| cmdWrite | input | 1 | Debug-port command is a write |
| cmdAttr | input | 8 | Debug-port command attributes {R,SZ,TT,TM} |
| cmdAddr | input | 32 | Debug-port command address |
| cmdData | input | 32 | Debug-port command write data |
| bkptEnable | input | 1 | Comparator enable |
| dataMode | input | 1 | 1 = data breakpoint, 0 = address breakpoint |
| dbgAccess | input | 1 | Current bus cycle is a debug-port access |
| busValid | input | 1 | Bus cycle valid |
| busRead | input | 1 | Bus read (1) / write (0) |
| busSize | input | 2 | Bus access size |
| busTt | input | 2 | Bus transfer type |
| busTm | input | 3 | Bus transfer modifier |
| busAddr | input | 32 | Bus address |
| busData | input | 32 | Bus data |
| trigger | output | 1 | One-cycle breakpoint pulse |

## Verification
Each attribute field is tested with a bus cycle whose difference falls on a masked bit, which must hit, and with one whose difference falls on an unmasked bit, which must miss. This separates per-bit masking from whole-field masking. Address and data are each tested with an exact match and with a single differing value. Further patterns issue debug-port read and write commands between setup and bus cycles, which shows what each command type overwrites and what it keeps. Separate bus cycles run with `dbgAccess` set, with the enable low, and with a same-cycle clash between a configuration write and a command write.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int ATTR_W = 16;
  localparam int FIELD_W = ATTR_W / 2;
  localparam logic [ATTR_W-1:0] ATTR_RESET = 16'h0005;

  localparam logic [1:0] SEL_ATTR = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  typedef struct packed {
    logic ldAttrAll;
    logic ldAttrLow;
    logic ldAddrCfg;
    logic ldAddrCmd;
    logic ldDataCfg;
    logic ldDataCmd;
    logic cmpEn;
  } strobeT;
endpackage

// File: rtl/bkpt_ctrl.sv
module bkpt_ctrl
  import bkpt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgSel,
  input  logic       cmdValid,
  input  logic       cmdWrite,
  input  logic       bkptEnable,
  input  logic       dbgAccess,
  input  logic       busValid,
  output strobeT     stb
);
  logic cmdWr;

  always_comb begin
    cmdWr         = cmdValid && cmdWrite;
    stb.ldAttrLow = cmdValid;
    stb.ldAttrAll = cfgWrEn && (cfgSel == SEL_ATTR) && !cmdValid;
    stb.ldAddrCmd = cmdValid;
    stb.ldAddrCfg = cfgWrEn && (cfgSel == SEL_ADDR) && !cmdValid;
    stb.ldDataCmd = cmdWr;
    stb.ldDataCfg = cfgWrEn && (cfgSel == SEL_DATA) && !cmdWr;
    stb.cmpEn     = busValid && bkptEnable && !dbgAccess;
  end

  // R12
  addr_load_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ldAddrCfg, stb.ldAddrCmd}));

  // R12
  attr_load_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ldAttrAll, stb.ldAttrLow}));
endmodule

// File: rtl/bkpt_datapath.sv
module bkpt_datapath
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic              dataMode,
  input  logic [ATTR_W-1:0] cfgAttr,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic [FIELD_W-1:0] cmdAttr,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [FIELD_W-1:0] busAttr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  output logic              trigQ
);
  logic [ATTR_W-1:0]  attrQ;
  logic [ADDR_W-1:0]  addrQ;
  logic [DATA_W-1:0]  dataQ;
  logic [FIELD_W-1:0] bitOk;
  logic attrHit, addrHit, dataHit, hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attrQ <= ATTR_RESET;
    end else if (stb.ldAttrLow) begin
      attrQ[FIELD_W-1:0] <= cmdAttr;
    end else if (stb.ldAttrAll) begin
      attrQ <= cfgAttr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (stb.ldAddrCmd) begin
      addrQ <= cmdAddr;
    end else if (stb.ldAddrCfg) begin
      addrQ <= cfgAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
    end else if (stb.ldDataCmd) begin
      dataQ <= cmdData;
    end else if (stb.ldDataCfg) begin
      dataQ <= cfgData;
    end
  end

  // each attribute bit i is masked by bit i+FIELD_W
  for (genvar i = 0; i < FIELD_W; i++) begin : g_attrBit
    assign bitOk[i] = attrQ[i+FIELD_W] || (attrQ[i] == busAttr[i]);
  end

  always_comb begin
    attrHit = &bitOk;
    addrHit = (busAddr == addrQ);
    dataHit = (busData == dataQ);
    hit     = stb.cmpEn && attrHit && addrHit && (!dataMode || dataHit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trigQ <= 1'b0;
    else       trigQ <= hit;
  end

  // R2
  trig_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigQ |-> $past(busAddr == addrQ));

  // R7
  trig_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigQ && $past(dataMode)) |-> $past(busData == dataQ));

  // R9
  cmd_addr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldAddrCmd |=> (addrQ == $past(cmdAddr)));

  // R10
  cmd_data_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldDataCmd |=> (dataQ == $past(cmdData)));

  // R9
  cmd_mask_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldAttrLow |=> $stable(attrQ[ATTR_W-1:FIELD_W]));
endmodule

// File: rtl/bkpt_attr_trigger.sv
module bkpt_attr_trigger
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [31:0]       cfgWrData,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic [7:0]        cmdAttr,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              bkptEnable,
  input  logic              dataMode,
  input  logic              dbgAccess,
  input  logic              busValid,
  input  logic              busRead,
  input  logic [1:0]        busSize,
  input  logic [1:0]        busTt,
  input  logic [2:0]        busTm,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  output logic              trigger
);
  strobeT stb;
  logic [FIELD_W-1:0] busAttr;

  assign busAttr = {busRead, busSize, busTt, busTm};

  bkpt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgSel     (cfgSel),
    .cmdValid   (cmdValid),
    .cmdWrite   (cmdWrite),
    .bkptEnable (bkptEnable),
    .dbgAccess  (dbgAccess),
    .busValid   (busValid),
    .stb        (stb)
  );

  bkpt_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .dataMode(dataMode),
    .cfgAttr (cfgWrData[ATTR_W-1:0]),
    .cfgAddr (cfgWrData[ADDR_W-1:0]),
    .cfgData (cfgWrData[DATA_W-1:0]),
    .cmdAttr (cmdAttr),
    .cmdAddr (cmdAddr),
    .cmdData (cmdData),
    .busAttr (busAttr),
    .busAddr (busAddr),
    .busData (busData),
    .trigQ   (trigger)
  );

  // R8
  dbg_access_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    dbgAccess |=> !trigger);

  // R11
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bkptEnable |=> !trigger);

  // R2
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> !trigger);
endmodule

// File: tb/tb_bkpt_attr_trigger.sv
`timescale 1ns/1ps
module tb_bkpt_attr_trigger;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 0;
  logic [1:0] cfgSel = 0;
  logic [31:0] cfgWrData = 0;
  logic cmdValid = 0, cmdWrite = 0;
  logic [7:0] cmdAttr = 0;
  logic [31:0] cmdAddr = 0, cmdData = 0;
  logic bkptEnable = 0, dataMode = 0, dbgAccess = 0;
  logic busValid = 0, busRead = 0;
  logic [1:0] busSize = 0, busTt = 0;
  logic [2:0] busTm = 0;
  logic [31:0] busAddr = 0, busData = 0;
  logic trigger;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bkpt_attr_trigger dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .cmdValid(cmdValid), .cmdWrite(cmdWrite), .cmdAttr(cmdAttr), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .bkptEnable(bkptEnable), .dataMode(dataMode), .dbgAccess(dbgAccess),
    .busValid(busValid), .busRead(busRead), .busSize(busSize), .busTt(busTt),
    .busTm(busTm), .busAddr(busAddr), .busData(busData), .trigger(trigger)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: trigger=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfgWrEn = 1; cfgSel = sel; cfgWrData = val;
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic dbgCmd(input logic wr, input logic [7:0] attr,
                        input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    cmdValid = 1; cmdWrite = wr; cmdAttr = attr; cmdAddr = addr; cmdData = data;
    @(negedge clk);
    cmdValid = 0; cmdWrite = 0;
  endtask

  task automatic busCycle(input logic rd, input logic [1:0] sz, input logic [1:0] tt,
                          input logic [2:0] tm, input logic [31:0] addr,
                          input logic [31:0] data, input logic acc,
                          input logic exp, input string tag);
    @(negedge clk);
    busValid = 1; busRead = rd; busSize = sz; busTt = tt; busTm = tm;
    busAddr = addr; busData = data; dbgAccess = acc;
    @(negedge clk);
    busValid = 0; dbgAccess = 0;
    check(trigger, exp, tag);
  endtask

  localparam logic [31:0] A0 = 32'h2000_0040;

  task automatic testReset();
    check(trigger, 1'b0, "R1 trigger low in reset");
    bkptEnable = 1;
    cfgWrite(2'd1, A0);
    busCycle(0, 2'b00, 2'b00, 3'b101, A0, 0, 0, 1, "R1 reset attr hit");
    busCycle(0, 2'b00, 2'b00, 3'b001, A0, 0, 0, 0, "R1 reset attr TM miss");
    busCycle(1, 2'b00, 2'b00, 3'b101, A0, 0, 0, 0, "R1 reset attr R miss");
  endtask

  task automatic testAddrMatch();
    cfgWrite(2'd0, 32'h0000_00B3);  // R=1 SZ=01 TT=10 TM=011
    busCycle(1, 2'b01, 2'b10, 3'b011, A0, 0, 0, 1, "R2 full match");
    @(negedge clk);
    check(trigger, 1'b0, "R2 single-cycle pulse");
    busCycle(1, 2'b01, 2'b10, 3'b011, A0 + 1, 0, 0, 0, "R2 address miss");
    busCycle(1, 2'b00, 2'b10, 3'b011, A0, 0, 0, 0, "R2 size miss");
  endtask

  task automatic testRwMask();
    busCycle(0, 2'b01, 2'b10, 3'b011, A0, 0, 0, 0, "R3 R unmasked miss");
    cfgWrite(2'd0, 32'h0000_80B3);
    busCycle(0, 2'b01, 2'b10, 3'b011, A0, 0, 0, 1, "R3 R masked hit");
  endtask

  task automatic testSizeMask();
    cfgWrite(2'd0, 32'h0000_40B3);  // mask SZ bit1 only
    busCycle(1, 2'b11, 2'b10, 3'b011, A0, 0, 0, 1, "R4 SZ bit1 masked hit");
    busCycle(1, 2'b00, 2'b10, 3'b011, A0, 0, 0, 0, "R4 SZ bit0 unmasked miss");
    busCycle(1, 2'b10, 2'b10, 3'b011, A0, 0, 0, 0, "R4 word vs byte miss");
  endtask

  task automatic testTtMask();
    cfgWrite(2'd0, 32'h0000_08B3);  // mask TT bit0 only
    busCycle(1, 2'b01, 2'b11, 3'b011, A0, 0, 0, 1, "R5 TT bit0 masked hit");
    busCycle(1, 2'b01, 2'b00, 3'b011, A0, 0, 0, 0, "R5 TT bit1 unmasked miss");
  endtask

  task automatic testTmMask();
    cfgWrite(2'd0, 32'h0000_07B3);
    busCycle(1, 2'b01, 2'b10, 3'b000, A0, 0, 0, 1, "R6 TM fully masked hit");
    cfgWrite(2'd0, 32'h0000_01B3);
    busCycle(1, 2'b01, 2'b10, 3'b010, A0, 0, 0, 1, "R6 TM bit0 masked hit");
    busCycle(1, 2'b01, 2'b10, 3'b001, A0, 0, 0, 0, "R6 TM bit1 unmasked miss");
  endtask

  task automatic testDataMode();
    cfgWrite(2'd0, 32'h0000_00B3);
    cfgWrite(2'd2, 32'hDEAD_BEEF);
    dataMode = 1;
    busCycle(1, 2'b01, 2'b10, 3'b011, A0, 32'hDEAD_BEEF, 0, 1, "R7 data hit");
    busCycle(1, 2'b01, 2'b10, 3'b011, A0, 32'hDEAD_BEEE, 0, 0, "R7 data miss");
    dataMode = 0;
    busCycle(1, 2'b01, 2'b10, 3'b011, A0, 32'h0, 0, 1, "R7 address mode ignores data");
  endtask

  task automatic testDbgAccess();
    busCycle(1, 2'b01, 2'b10, 3'b011, A0, 0, 1, 0, "R8 debug access suppressed");
    busCycle(1, 2'b01, 2'b10, 3'b011, A0, 0, 0, 1, "R8 normal access hits");
  endtask

  task automatic testEnable();
    bkptEnable = 0;
    busCycle(1, 2'b01, 2'b10, 3'b011, A0, 0, 0, 0, "R11 disabled no trigger");
    bkptEnable = 1;
  endtask

  task automatic testCmdOverwrite();
    cfgWrite(2'd0, 32'h0000_40B3);
    dbgCmd(0, 8'h00, 32'h3000_0000, 32'h0);
    busCycle(1, 2'b01, 2'b10, 3'b011, A0, 0, 0, 0, "R9 old breakpoint destroyed");
    busCycle(0, 2'b10, 2'b00, 3'b000, 32'h3000_0000, 0, 0, 1, "R9 cmd attr+addr, mask kept");
  endtask

  task automatic testCmdData();
    cfgWrite(2'd2, 32'h1111_2222);
    dataMode = 1;
    dbgCmd(0, 8'h00, 32'h3000_0000, 32'h5555_6666);
    busCycle(0, 2'b00, 2'b00, 3'b000, 32'h3000_0000, 32'h1111_2222, 0, 1, "R10 read cmd keeps data");
    dbgCmd(1, 8'h00, 32'h3000_0000, 32'h5555_6666);
    busCycle(0, 2'b00, 2'b00, 3'b000, 32'h3000_0000, 32'h5555_6666, 0, 1, "R10 write cmd loads data");
    busCycle(0, 2'b00, 2'b00, 3'b000, 32'h3000_0000, 32'h1111_2222, 0, 0, "R10 old data gone");
    dataMode = 0;
  endtask

  task automatic testCfgSel();
    cfgWrite(2'd3, 32'h4444_0000);
    busCycle(0, 2'b00, 2'b00, 3'b000, 32'h3000_0000, 0, 0, 1, "R12 sel 3 ignored");
    @(negedge clk);
    cfgWrEn = 1; cfgSel = 2'd1; cfgWrData = 32'h7000_0000;
    cmdValid = 1; cmdWrite = 0; cmdAttr = 8'h00; cmdAddr = 32'h7100_0000;
    @(negedge clk);
    cfgWrEn = 0; cmdValid = 0;
    busCycle(0, 2'b00, 2'b00, 3'b000, 32'h7100_0000, 0, 0, 1, "R12 command wins clash");
    busCycle(0, 2'b00, 2'b00, 3'b000, 32'h7000_0000, 0, 0, 0, "R12 clashing cfg dropped");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset_pre: begin
      check(trigger, 1'b0, "R1 trigger low during reset");
    end
    rstN = 1;
    testReset();
    testAddrMatch();
    testRwMask();
    testSizeMask();
    testTtMask();
    testTmMask();
    testDataMode();
    testDbgAccess();
    testEnable();
    testCmdOverwrite();
    testCmdData();
    testCfgSel();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule